// File: doc/BRIEF.md
# Single-Bit Error Injector with Retime

This block sits in the serial NRZ path of a bit-error-rate test transmitter. It takes the bit stream from a pseudo-random pattern source and, on request from a front-panel pushbutton, corrupts exactly one bit by inverting it. A rising edge on the synchronized button level arms a one-shot. The next valid bit leaves inverted, and the one-shot clears in that same cycle.

The stream, with or without its single error, is then retimed into two output paths, unbalanced and balanced. Each path registers its data on the same edge as its enable, so data and timing stay aligned. A two-bit rate-decode input picks which path is live. A path that is not selected drives both data and enable at 0.

The arming logic is a two-state machine:
- `ST_IDLE`: no error pending.
- `ST_ARMED`: one error pending.
- `T_ARM` (`ST_IDLE` to `ST_ARMED`): taken on a detected press.
- `T_FIRE` (`ST_ARMED` to `ST_IDLE`): taken on the first valid bit while armed. That bit is inverted.

A press seen in `ST_ARMED` has no effect.

Top module: `single_error_injector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, all four outputs are 0 and no error is pending.
- R2: The button level passes through two synchronizing flip-flops. A press is its 0-to-1 transition, and a held button produces only one error.
- R3: Once armed, the first cycle with `in_valid`=1 has its bit inverted (1 goes out as 0, 0 goes out as 1). The one-shot clears in that cycle, so exactly one bit per press is corrupted.
- R4: A press detected while already armed, including one in the cycle the error fires, is discarded and does not queue another error.
- R5: Bits leave unchanged when not armed. This includes a bit whose cycle coincides with the press that arms the one-shot; the inversion falls on the following valid bit.
- R6: The unbalanced path is selected when `rate_sel`==2'b00 (bit 0 and bit 1 are the two rate-decode lines). When selected, `unbal_en` one cycle later equals `in_valid`, and `unbal_data` is the (possibly inverted) bit registered on that same edge.
- R7: The balanced path is selected whenever `rate_sel[1]`==1, whatever `rate_sel[0]` is. It retimes with the same one-cycle latency as R6.
- R8: A path that is not selected drives data 0 and enable 0 from the next edge. With `rate_sel`==2'b01 both paths are off.
- R9: A selected path in a cycle with `in_valid`=0 drives enable 0 and keeps its previous data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bit | input | 1 | Serial data bit from the pattern source |
| in_valid | input | 1 | Marks the cycle in which `in_bit` is a new bit |
| btn_async | input | 1 | Asynchronous single-error button level |
| rate_sel | input | 2 | Rate-decode lines: bit 0 low-family decode, bit 1 high-family decode |
| unbal_data | output | 1 | Retimed data, unbalanced path |
| unbal_en | output | 1 | Bit-enable aligned with `unbal_data` |
| bal_data | output | 1 | Retimed data, balanced path |
| bal_en | output | 1 | Bit-enable aligned with `bal_data` |

## Verification
A detected press and a valid bit can fall in the same cycle. Which state the machine is in then decides the outcome. In `ST_IDLE` the press arms and the current bit must pass unchanged. In `ST_ARMED` the bit is inverted and the press is lost.

A held button with `in_valid` high in every cycle provokes the first case directed. Long random runs, with sparse button toggles and random bit-enables, provoke both cases many times. Every cycle is judged against a bench model of the sync chain and the one-shot. A separate count of inverted bits per held press must come out at exactly one.

// File: rtl/sei_pkg.sv
package sei_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;

    localparam int SYNC_STAGES = 2;
    localparam int RATE_W      = 2;
    localparam int NUM_PATHS   = 2;
    localparam int PATH_UNBAL  = 0;
    localparam int PATH_BAL    = 1;
endpackage

// File: rtl/sei_press_detect.sv
module sei_press_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_async,
    output logic press
);
    // STAGES synchronizer flops plus one delay flop for the edge detect
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], btn_async};
    end

    assign press = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sei_arm_fsm.sv
module sei_arm_fsm
    import sei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press,
    input  logic in_valid,
    output logic armed,
    output logic flip
);
    arm_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        flip     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (press) state_nx = ST_ARMED;        // T_ARM
            end
            ST_ARMED: begin
                if (in_valid) begin                    // T_FIRE
                    flip     = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign armed = (state == ST_ARMED);
endmodule

// File: rtl/sei_retime.sv
module sei_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic path_on,
    input  logic bit_valid,
    input  logic bit_in,
    output logic q_data,
    output logic q_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= 1'b0;
            q_en   <= 1'b0;
        end else if (!path_on) begin
            q_data <= 1'b0;
            q_en   <= 1'b0;
        end else begin
            q_en <= bit_valid;
            if (bit_valid) q_data <= bit_in;
        end
    end
endmodule

// File: rtl/single_error_injector.sv
module single_error_injector
    import sei_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_bit,
    input  logic              in_valid,
    input  logic              btn_async,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              unbal_data,
    output logic              unbal_en,
    output logic              bal_data,
    output logic              bal_en
);
    logic                 press;
    logic                 armed;
    logic                 flip;
    logic                 tx_bit;
    logic [NUM_PATHS-1:0] path_sel;
    logic [NUM_PATHS-1:0] rt_data;
    logic [NUM_PATHS-1:0] rt_en;

    sei_press_detect #(.STAGES(SYNC_STAGES)) u_press (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_async (btn_async),
        .press     (press)
    );

    sei_arm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .press    (press),
        .in_valid (in_valid),
        .armed    (armed),
        .flip     (flip)
    );

    assign tx_bit = in_bit ^ flip;

    assign path_sel[PATH_UNBAL] = ~rate_sel[0] & ~rate_sel[1];
    assign path_sel[PATH_BAL]   = rate_sel[1];

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        sei_retime u_rt (
            .clk       (clk),
            .rst_n     (rst_n),
            .path_on   (path_sel[p]),
            .bit_valid (in_valid),
            .bit_in    (tx_bit),
            .q_data    (rt_data[p]),
            .q_en      (rt_en[p])
        );
    end

    assign unbal_data = rt_data[PATH_UNBAL];
    assign unbal_en   = rt_en[PATH_UNBAL];
    assign bal_data   = rt_data[PATH_BAL];
    assign bal_en     = rt_en[PATH_BAL];
endmodule

// File: rtl/sei_checker.sv
module sei_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_bit,
    input logic       in_valid,
    input logic [1:0] rate_sel,
    input logic       armed,
    input logic       unbal_data,
    input logic       unbal_en,
    input logic       bal_data,
    input logic       bal_en
);
    // R3: a valid bit while armed clears the one-shot
    p_fire_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && in_valid |=> !armed);

    // R4: without a valid bit an armed one-shot stays armed, whatever the button does
    p_stays_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !in_valid |=> armed);

    // R5/R3: emitted unbalanced bit is the input bit, inverted only when armed
    p_unbal_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unbal_en |-> unbal_data == ($past(in_bit) ^ $past(armed)));

    p_bal_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bal_en |-> bal_data == ($past(in_bit) ^ $past(armed)));

    // R6: unbalanced enable follows a selected valid bit by one cycle
    p_unbal_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rate_sel == 2'b00 |=> unbal_en);

    // R7: balanced enable follows a selected valid bit by one cycle
    p_bal_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rate_sel[1] |=> bal_en);

    // R8: rate code 01 silences both paths
    p_both_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rate_sel == 2'b01 |=> !unbal_en && !bal_en && !unbal_data && !bal_data);

    // R8: the two paths are never live together
    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(unbal_en && bal_en));

    // R9: a selected path holds its data when no bit arrives
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rate_sel == 2'b00 && !in_valid |=> !unbal_en && $stable(unbal_data));
endmodule

bind single_error_injector sei_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_bit     (in_bit),
    .in_valid   (in_valid),
    .rate_sel   (rate_sel),
    .armed      (armed),
    .unbal_data (unbal_data),
    .unbal_en   (unbal_en),
    .bal_data   (bal_data),
    .bal_en     (bal_en)
);

// File: tb/sim_single_error_injector.sv
`timescale 1ns/1ps
module sim_single_error_injector;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_bit, in_valid, btn_async;
    logic [1:0] rate_sel;
    logic       unbal_data, unbal_en, bal_data, bal_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int flips_seen = 0;

    // bench model state
    logic m_s1, m_s2, m_d, m_armed, m_ud, m_bd;

    always #10 clk = ~clk;   // 50 MHz

    single_error_injector u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_bit     (in_bit),
        .in_valid   (in_valid),
        .btn_async  (btn_async),
        .rate_sel   (rate_sel),
        .unbal_data (unbal_data),
        .unbal_en   (unbal_en),
        .bal_data   (bal_data),
        .bal_en     (bal_en)
    );

    function automatic logic exp_bit(input logic b, input logic v, input logic armed);
        return b ^ (armed & v);
    endfunction

    function automatic logic exp_data(input logic sel, input logic v, input logic nb, input logic prev);
        if (!sel) return 1'b0;
        return v ? nb : prev;
    endfunction

    function automatic logic exp_armed(input logic armed, input logic v, input logic press);
        return armed ? ~v : press;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // one bit-clock cycle: drive, predict, sample after the edge, advance model
    task automatic cycle(input logic b, input logic d, input logic v, input logic [1:0] r);
        logic press, nb, usel, bsel;
        logic [3:0] exp, act;
        string tag;
        @(negedge clk);
        btn_async = b; in_bit = d; in_valid = v; rate_sel = r;
        press = m_s2 & ~m_d;
        nb    = exp_bit(d, v, m_armed);
        usel  = (r == 2'b00);
        bsel  = r[1];
        exp   = {exp_data(usel, v, nb, m_ud), usel & v, exp_data(bsel, v, nb, m_bd), bsel & v};
        @(posedge clk);
        #2;
        act = {unbal_data, unbal_en, bal_data, bal_en};
        if (m_armed && v)   tag = "R3";
        else if (press)     tag = "R5";
        else if (r == 2'b01) tag = "R8";
        else if (!v)        tag = "R9";
        else if (usel)      tag = "R6";
        else                tag = "R7";
        check(act == exp, tag, "outputs {ud,ue,bd,be}", act, exp);
        if ((unbal_en && unbal_data != d) || (bal_en && bal_data != d)) flips_seen++;
        m_ud    = exp[3];
        m_bd    = exp[1];
        m_armed = exp_armed(m_armed, v, press);
        m_d  = m_s2;
        m_s2 = m_s1;
        m_s1 = b;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic b;
        process::self().srandom(32'h5E1_0A7);
        rst_n = 1'b0; in_bit = 0; in_valid = 0; btn_async = 0; rate_sel = 2'b00;
        {m_s1, m_s2, m_d, m_armed, m_ud, m_bd} = '0;
        // R1: outputs during reset, with activity on the inputs
        repeat (2) @(posedge clk);
        @(negedge clk); in_valid = 1; in_bit = 1; btn_async = 1;
        @(posedge clk); #2;
        check({unbal_data, unbal_en, bal_data, bal_en} == 4'b0, "R1", "reset outputs",
              {unbal_data, unbal_en, bal_data, bal_en}, 4'b0);
        @(negedge clk); rst_n = 1; in_valid = 0; btn_async = 0;
        @(posedge clk); #2;
        check({unbal_data, unbal_en, bal_data, bal_en} == 4'b0, "R1", "first cycle after reset",
              {unbal_data, unbal_en, bal_data, bal_en}, 4'b0);

        // R5: clean pass-through, alternating bits
        for (int i = 0; i < 8; i++) cycle(0, i[0], 1, 2'b00);

        // R2/R5: held button with a bit every cycle -> exactly one inversion
        flips_seen = 0;
        for (int i = 0; i < 30; i++) cycle(1, i[1], 1, 2'b00);
        for (int i = 0; i < 5; i++)  cycle(0, 1, 1, 2'b00);
        check(flips_seen == 1, "R2", "inversions for one held press", 4'(flips_seen), 4'd1);

        // R4: second press while armed with no bits flowing is discarded
        flips_seen = 0;
        for (int i = 0; i < 4; i++)  cycle(1, 0, 0, 2'b00);
        for (int i = 0; i < 3; i++)  cycle(0, 0, 0, 2'b00);
        for (int i = 0; i < 4; i++)  cycle(1, 0, 0, 2'b00);
        for (int i = 0; i < 12; i++) cycle(0, 0, 1, 2'b00);
        check(flips_seen == 1, "R4", "inversions for press while armed", 4'(flips_seen), 4'd1);

        // R3 on the balanced path, both rate codes that select it
        flips_seen = 0;
        for (int i = 0; i < 4; i++)  cycle(1, 1, 0, 2'b10);
        for (int i = 0; i < 6; i++)  cycle(0, 1, 1, 2'b11);
        check(flips_seen == 1, "R3", "balanced-path inversion count", 4'(flips_seen), 4'd1);

        // R7/R8/R9 rate sweep with gaps
        for (int r = 0; r < 4; r++)
            for (int i = 0; i < 6; i++) cycle(0, i[0] ^ r[0], i != 2 && i != 3, 2'(r));
        for (int i = 0; i < 4; i++) cycle(0, 1, 1, 2'b01);

        // constrained random: sparse button toggles, random enables and rates
        b = 0;
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] r;
            if ($urandom_range(0, 9) == 0) b = ~b;
            r = ($urandom_range(0, 19) == 0) ? 2'($urandom) : rate_sel;
            cycle(b, 1'($urandom), $urandom_range(0, 3) != 0, r);
        end

        finish_run();
    end
endmodule